// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block sits beside the shift engine of a serial controller. It holds the transmit and receive FIFOs and watches how full each one is. It raises interrupt flags when each FIFO crosses its own programmable trigger level, when a received word is lost because the receive FIFO is full, and when the shift engine reports the end of a transfer. Software fills the transmit FIFO and empties the receive FIFO through direct push and pop ports. The shift engine pops transmit words and pushes received words through its own pair of ports.

A small register window, selected by a 2-bit word index, gives four registers:

- **Index 0, FIFO control:** the two 8-bit trigger levels and two flush bits. Each flush bit acts for one cycle and always reads back as 0.
- **Index 1, FIFO status:** read only. It packs both occupancy counts into one word.
- **Index 2, interrupt enable.**
- **Index 3, interrupt status:** write-one-to-clear.

Status and enable use the same bit positions. The single interrupt output is high while any enabled status bit is set.

The threshold flags behave as levels. Clearing one has no lasting effect while its condition still holds, so a handler has to service the FIFO before the flag stays low. The FIFO depth is a parameter and must be 64 or 128. Reset is synchronous and active high.

Top module: `fifo_watermark_irq`

## Requirements
- R1: Reset state:
  - FIFO control reads back both trigger levels equal to three quarters of the depth (96 for depth 128), so it reads 32'h0060_0060.
  - FIFO status reads 0, interrupt enable reads 0 and `irq` is low.
  - Interrupt status reads 0 while reset is held.
- R2: FIFO data and counts:
  - Each FIFO returns words in the order they were pushed, and its head word is shown on its read-data port.
  - FIFO status (index 1) carries the receive count in bits 7:0 and the transmit count in bits 23:16; all other bits are 0.
  - A push to a full transmit FIFO is dropped.
- R3: Receive-ready, status bit 0, sets on the clock edge after the receive count is greater than or equal to the receive trigger level.
- R4: Transmit-request, status bit 4, sets on the clock edge after the transmit count is less than or equal to the transmit trigger level.
- R5: Receive overflow, status bit 8:
  - It sets on the edge after a receive push arrives while the receive FIFO holds depth words.
  - That word is dropped, and the count and stored data are unchanged.
- R6: Transfer-complete, status bit 12, sets on the edge after a one-cycle pulse on `xfer_done`.
- R7: Writing the interrupt status register (index 3) works as write-one-to-clear:
  - A 1 clears that status bit, unless its set condition is active in the same cycle.
  - A 0 leaves the bit unchanged.
  - Writing all ones clears every bit whose condition is inactive.
- R8: A threshold bit that software clears while its condition still holds reads 1 again on the following cycle.
- R9: FIFO control (index 0) layout:
  - The receive level is in bits 7:0 and the transmit level in bits 23:16.
  - Writing 1 to bit 15 empties the receive FIFO; writing 1 to bit 31 empties the transmit FIFO.
  - Bits 15 and 31 read back as 0.
- R10: Interrupt enable (index 2) uses the status bit positions 0, 4, 8 and 12. `irq` is high exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index (0 FIFO control, 1 FIFO status, 2 enable, 3 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| tx_push | input | 1 | Software pushes a word into the transmit FIFO |
| tx_wdata | input | DW | Word to push into the transmit FIFO |
| tx_pop | input | 1 | Shift engine takes the transmit head word |
| tx_rdata | output | DW | Transmit FIFO head word |
| rx_push | input | 1 | Shift engine pushes a received word |
| rx_wdata | input | DW | Received word |
| rx_pop | input | 1 | Software takes the receive head word |
| rx_rdata | output | DW | Receive FIFO head word |
| xfer_done | input | 1 | One-cycle pulse marking the end of a transfer |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that `xfer_done` is a single-cycle pulse. They also assume that the register inputs are steady around the clock edge, so that each write takes effect in exactly one cycle. The overflow property assumes that no receive flush is written in the same cycle as the push that overflows.

The bench changes every input only on the falling clock edge. It drives `xfer_done` for exactly one cycle. It never issues a flush in the same cycle as a push, so the stimulus stays inside these assumptions.

// File: rtl/fwirq_pkg.sv
package fwirq_pkg;

    localparam int CNT_W = 8;
    localparam int LVL_W = 8;

    typedef enum logic [1:0] {
        ADDR_FIFO_CTRL = 2'd0,
        ADDR_FIFO_STAT = 2'd1,
        ADDR_IRQ_EN    = 2'd2,
        ADDR_IRQ_STAT  = 2'd3
    } reg_addr_e;

    // Interrupt bit positions, shared by the enable and status registers.
    localparam int BIT_RX_READY  = 0;
    localparam int BIT_TX_REQ    = 4;
    localparam int BIT_RX_OVF    = 8;
    localparam int BIT_XFER_DONE = 12;

    // FIFO control field positions.
    localparam int CTL_RX_LVL_LSB = 0;
    localparam int CTL_RX_FLUSH   = 15;
    localparam int CTL_TX_LVL_LSB = 16;
    localparam int CTL_TX_FLUSH   = 31;

    // FIFO status field positions.
    localparam int STA_RX_CNT_LSB = 0;
    localparam int STA_TX_CNT_LSB = 16;

    localparam int N_IRQ = 4;

    typedef struct packed {
        logic xfer_done;
        logic rx_ovf;
        logic tx_req;
        logic rx_ready;
    } irq_vec_t;

    typedef struct packed {
        logic [LVL_W-1:0] tx_lvl;
        logic [LVL_W-1:0] rx_lvl;
    } lvl_cfg_t;

    function automatic irq_vec_t pick_irq(input logic b_done, input logic b_ovf,
                                          input logic b_req, input logic b_rdy);
        irq_vec_t v;
        v.xfer_done = b_done;
        v.rx_ovf    = b_ovf;
        v.tx_req    = b_req;
        v.rx_ready  = b_rdy;
        return v;
    endfunction

    function automatic logic [31:0] irq_to_word(input irq_vec_t v);
        logic [31:0] w;
        w = '0;
        w[BIT_RX_READY]  = v.rx_ready;
        w[BIT_TX_REQ]    = v.tx_req;
        w[BIT_RX_OVF]    = v.rx_ovf;
        w[BIT_XFER_DONE] = v.xfer_done;
        return w;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input lvl_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[CTL_RX_LVL_LSB +: LVL_W] = c.rx_lvl;
        w[CTL_TX_LVL_LSB +: LVL_W] = c.tx_lvl;
        return w;
    endfunction

    function automatic logic [31:0] counts_to_word(input logic [CNT_W-1:0] rx_c,
                                                   input logic [CNT_W-1:0] tx_c);
        logic [31:0] w;
        w = '0;
        w[STA_RX_CNT_LSB +: CNT_W] = rx_c;
        w[STA_TX_CNT_LSB +: CNT_W] = tx_c;
        return w;
    endfunction

endpackage

// File: rtl/fwirq_fifo.sv
module fwirq_fifo #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          drop
);
    localparam int            PTR_W    = $clog2(DEPTH);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wp;
    logic [PTR_W-1:0] rp;
    logic             full;
    logic             empty;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign drop    = push && full && !flush;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (!rst && do_push) begin
            mem[wp] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wp <= wp + 1'b1;
            end
            if (do_pop) begin
                rp <= rp + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/fwirq_status.sv
module fwirq_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    input  logic [N-1:0] en_v,
    output logic [N-1:0] sts,
    output logic         irq
);
    logic [N-1:0] live;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // A set request in the same cycle outranks a software clear.
        always_ff @(posedge clk) begin
            if (rst) begin
                sts[i] <= 1'b0;
            end else begin
                sts[i] <= set_v[i] | (sts[i] & ~clr_v[i]);
            end
        end
        assign live[i] = sts[i] & en_v[i];
    end

    assign irq = |live;

endmodule

// File: rtl/fifo_watermark_irq.sv
module fifo_watermark_irq
    import fwirq_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_wdata,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_rdata,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_wdata,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_rdata,
    input  logic          xfer_done,
    output logic          irq
);
    localparam logic [LVL_W-1:0] LVL_RST = LVL_W'(DEPTH / 4 * 3);

    lvl_cfg_t          lvl;
    irq_vec_t          irq_en;
    irq_vec_t          irq_sts;
    irq_vec_t          irq_set;
    irq_vec_t          irq_clr;
    logic [CNT_W-1:0]  rx_cnt;
    logic [CNT_W-1:0]  tx_cnt;
    logic              rx_drop;
    logic              tx_drop;
    logic              ctrl_wr;
    logic              en_wr;
    logic              sts_wr;
    logic              rx_flush;
    logic              tx_flush;
    logic              unused_bits;

    assign ctrl_wr  = reg_wr && (reg_addr == ADDR_FIFO_CTRL);
    assign en_wr    = reg_wr && (reg_addr == ADDR_IRQ_EN);
    assign sts_wr   = reg_wr && (reg_addr == ADDR_IRQ_STAT);
    assign rx_flush = ctrl_wr && reg_wdata[CTL_RX_FLUSH];
    assign tx_flush = ctrl_wr && reg_wdata[CTL_TX_FLUSH];

    assign unused_bits = ^{reg_wdata[30:24], reg_wdata[14:13], reg_wdata[11:9], tx_drop};

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl.rx_lvl <= LVL_RST;
            lvl.tx_lvl <= LVL_RST;
            irq_en     <= '0;
        end else begin
            if (ctrl_wr) begin
                lvl.rx_lvl <= reg_wdata[CTL_RX_LVL_LSB +: LVL_W];
                lvl.tx_lvl <= reg_wdata[CTL_TX_LVL_LSB +: LVL_W];
            end
            if (en_wr) begin
                irq_en <= pick_irq(reg_wdata[BIT_XFER_DONE], reg_wdata[BIT_RX_OVF],
                                   reg_wdata[BIT_TX_REQ], reg_wdata[BIT_RX_READY]);
            end
        end
    end

    // FIFOs
    fwirq_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CNT_W)) u_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (tx_flush),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_rdata),
        .count (tx_cnt),
        .drop  (tx_drop)
    );

    fwirq_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CNT_W)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (rx_flush),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .count (rx_cnt),
        .drop  (rx_drop)
    );

    // Interrupt sources and software clears
    always_comb begin
        irq_set = pick_irq(xfer_done, rx_drop, (tx_cnt <= lvl.tx_lvl), (rx_cnt >= lvl.rx_lvl));
        if (sts_wr) begin
            irq_clr = pick_irq(reg_wdata[BIT_XFER_DONE], reg_wdata[BIT_RX_OVF],
                               reg_wdata[BIT_TX_REQ], reg_wdata[BIT_RX_READY]);
        end else begin
            irq_clr = '0;
        end
    end

    fwirq_status #(.N(N_IRQ)) u_status (
        .clk   (clk),
        .rst   (rst),
        .set_v (irq_set),
        .clr_v (irq_clr),
        .en_v  (irq_en),
        .sts   (irq_sts),
        .irq   (irq)
    );

    // Register read mux
    always_comb begin
        case (reg_addr)
            ADDR_FIFO_CTRL: reg_rdata = ctrl_to_word(lvl);
            ADDR_FIFO_STAT: reg_rdata = counts_to_word(rx_cnt, tx_cnt);
            ADDR_IRQ_EN:    reg_rdata = irq_to_word(irq_en);
            default:        reg_rdata = irq_to_word(irq_sts);
        endcase
    end

endmodule

// File: rtl/fwirq_checker.sv
module fwirq_checker #(
    parameter int DEPTH = 128
) (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic       wd_rx_flush,
    input logic       wd_done_bit,
    input logic       rx_push,
    input logic       xfer_done,
    input logic       irq,
    input logic [7:0] rx_cnt,
    input logic [7:0] tx_cnt,
    input logic [7:0] rx_lvl,
    input logic [7:0] tx_lvl,
    input logic [3:0] irq_sts,
    input logic [3:0] irq_en
);
    localparam logic [7:0] FULL = 8'(DEPTH);

    // R2: counts never exceed the depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt <= FULL) && (tx_cnt <= FULL));

    // R3: receive-ready follows its threshold
    a_r3_rx_ready_sets: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt >= rx_lvl) |=> irq_sts[0]);

    // R4: transmit-request follows its threshold
    a_r4_tx_req_sets: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt <= tx_lvl) |=> irq_sts[1]);

    // R5: push into a full receive FIFO flags overflow and keeps the count
    a_r5_overflow_sets: assert property (@(posedge clk) disable iff (rst)
        (rx_push && (rx_cnt == FULL) && !(reg_wr && reg_addr == 2'd0 && wd_rx_flush))
        |=> irq_sts[2]);

    // R6: transfer-complete pulse is captured
    a_r6_done_sets: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> irq_sts[3]);

    // R7: write-one clears transfer-complete when no new pulse arrives
    a_r7_done_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd3 && wd_done_bit && !xfer_done) |=> !irq_sts[3]);

    // R9: receive flush empties the FIFO
    a_r9_rx_flush: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && wd_rx_flush) |=> (rx_cnt == 8'd0));

    // R10: nothing enabled means no interrupt
    a_r10_masked: assert property (@(posedge clk) disable iff (rst)
        (irq_en == 4'd0) |-> !irq);

endmodule

bind fifo_watermark_irq fwirq_checker #(.DEPTH(DEPTH)) u_fwirq_checker (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .wd_rx_flush (reg_wdata[15]),
    .wd_done_bit (reg_wdata[12]),
    .rx_push     (rx_push),
    .xfer_done   (xfer_done),
    .irq         (irq),
    .rx_cnt      (rx_cnt),
    .tx_cnt      (tx_cnt),
    .rx_lvl      (lvl.rx_lvl),
    .tx_lvl      (lvl.tx_lvl),
    .irq_sts     (irq_sts),
    .irq_en      (irq_en)
);

// File: tb/test_fifo_watermark_irq.sv
module test_fifo_watermark_irq;

    localparam int DEPTH = 128;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          tx_push = 1'b0;
    logic [DW-1:0] tx_wdata = '0;
    logic          tx_pop = 1'b0;
    logic [DW-1:0] tx_rdata;
    logic          rx_push = 1'b0;
    logic [DW-1:0] rx_wdata = '0;
    logic          rx_pop = 1'b0;
    logic [DW-1:0] rx_rdata;
    logic          xfer_done = 1'b0;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    fifo_watermark_irq #(.DEPTH(DEPTH), .DW(DW)) i_fifo_watermark_irq (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tx_push   (tx_push),
        .tx_wdata  (tx_wdata),
        .tx_pop    (tx_pop),
        .tx_rdata  (tx_rdata),
        .rx_push   (rx_push),
        .rx_wdata  (rx_wdata),
        .rx_pop    (rx_pop),
        .rx_rdata  (rx_rdata),
        .xfer_done (xfer_done),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic push_rx(input logic [DW-1:0] d);
        @(negedge clk);
        rx_push = 1'b1; rx_wdata = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic push_tx(input logic [DW-1:0] d);
        @(negedge clk);
        tx_push = 1'b1; tx_wdata = d;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_rx(output logic [DW-1:0] d);
        @(negedge clk);
        d = rx_rdata;
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic pop_tx(output logic [DW-1:0] d);
        @(negedge clk);
        d = tx_rdata;
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        idle(2);
        rd(2'd3, d); chk("R1 status in reset", d, 32'h0);
        chk("R1 irq in reset", {31'b0, irq}, 32'h0);
        @(negedge clk); rst = 1'b0;
        idle(1);
        rd(2'd0, d); chk("R1 control reset", d, 32'h0060_0060);
        rd(2'd1, d); chk("R1 fifo status reset", d, 32'h0);
        rd(2'd2, d); chk("R1 enable reset", d, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(2'd3, d); chk("R4 tx request on empty fifo", d, 32'h0000_0010);
    endtask

    task automatic t_rx_threshold();
        logic [31:0] d;
        logic [DW-1:0] w;
        wr(2'd0, 32'h0060_0004);
        for (int i = 0; i < 3; i++) push_rx(8'hA0 + 8'(i));
        idle(2);
        rd(2'd3, d); chk("R3 below rx level", d & 32'h1, 32'h0);
        push_rx(8'hA3);
        idle(2);
        rd(2'd3, d); chk("R3 rx level reached", d & 32'h1, 32'h1);
        wr(2'd3, 32'h1);
        idle(1);
        rd(2'd3, d); chk("R8 rx ready re-sets", d & 32'h1, 32'h1);
        pop_rx(w); chk("R2 rx order", {24'b0, w}, 32'h0000_00A0);
        idle(1);
        rd(2'd1, d); chk("R2 rx count field", d, 32'h0000_0003);
        wr(2'd3, 32'h1);
        idle(1);
        rd(2'd3, d); chk("R7 rx ready cleared", d & 32'h1, 32'h0);
    endtask

    task automatic t_tx_threshold();
        logic [31:0] d;
        logic [DW-1:0] w;
        wr(2'd0, 32'h0002_0004);
        for (int i = 0; i < 5; i++) push_tx(8'hB0 + 8'(i));
        idle(2);
        rd(2'd1, d); chk("R2 packed counts", d, 32'h0005_0003);
        wr(2'd3, 32'hFFFF_FFFF);
        idle(1);
        rd(2'd3, d); chk("R7 all ones clear", d, 32'h0);
        for (int i = 0; i < 3; i++) begin
            pop_tx(w); chk("R2 tx order", {24'b0, w}, {24'b0, 8'hB0 + 8'(i)});
        end
        idle(2);
        rd(2'd3, d); chk("R4 tx drained to level", d, 32'h0000_0010);
    endtask

    task automatic t_flush();
        logic [31:0] d;
        wr(2'd0, 32'h8002_8004);
        idle(1);
        rd(2'd1, d); chk("R9 both fifos flushed", d, 32'h0);
        rd(2'd0, d); chk("R9 flush bits read zero", d, 32'h0002_0004);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        logic [DW-1:0] w;
        int bad;
        wr(2'd0, 32'h0002_00C8);
        wr(2'd3, 32'hFFFF_FFFF);
        for (int i = 0; i < DEPTH; i++) push_rx(8'(i));
        idle(2);
        rd(2'd1, d); chk("R2 rx full count", d & 32'hFF, 32'h80);
        rd(2'd3, d); chk("R5 no overflow at full", d & 32'h100, 32'h0);
        push_rx(8'hEE);
        idle(2);
        rd(2'd3, d); chk("R5 overflow flagged", d & 32'h100, 32'h100);
        rd(2'd1, d); chk("R5 count unchanged", d & 32'hFF, 32'h80);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            pop_rx(w);
            if (w !== 8'(i)) bad++;
        end
        chk("R5 dropped word absent, data intact", 32'(bad), 32'h0);
        for (int i = 0; i <= DEPTH; i++) push_tx(8'(i));
        idle(1);
        rd(2'd1, d); chk("R2 tx push when full dropped", d, 32'h0080_0000);
        wr(2'd0, 32'h8002_00C8);
        idle(1);
    endtask

    task automatic t_done();
        logic [31:0] d;
        wr(2'd3, 32'hFFFF_FFFF);
        pulse_done();
        idle(1);
        rd(2'd3, d); chk("R6 transfer complete set", d & 32'h1000, 32'h1000);
        wr(2'd3, 32'h0000_0101);
        idle(1);
        rd(2'd3, d); chk("R7 zero bits leave status", d & 32'h1000, 32'h1000);
        wr(2'd3, 32'h0000_1000);
        idle(1);
        rd(2'd3, d); chk("R7 transfer complete cleared", d & 32'h1000, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(2'd2, 32'h0000_1000);
        idle(1);
        chk("R10 enabled bit idle", {31'b0, irq}, 32'h0);
        pulse_done();
        idle(1);
        chk("R10 irq on enabled done", {31'b0, irq}, 32'h1);
        wr(2'd3, 32'h0000_1000);
        idle(1);
        chk("R10 irq drops after clear", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'h0000_0010);
        idle(1);
        rd(2'd2, d); chk("R10 enable readback", d, 32'h0000_0010);
        chk("R10 irq on tx request", {31'b0, irq}, 32'h1);
        wr(2'd2, 32'h0);
        idle(1);
        chk("R10 irq masked", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_rx_threshold();
        t_tx_threshold();
        t_flush();
        t_overflow();
        t_done();
        t_irq();
        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule